// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a 32-bit load/store processor core that finishes every instruction in one clock cycle. In that single cycle it fetches a word from a private instruction array, reads two source registers, runs the ALU, optionally reads or writes a private data array, and writes the result back. The program counter, the register file and the data array all commit together on the next rising edge. A purely combinational decoder turns the opcode and function fields into the control bundle: immediate mode, second-operand source, ALU operation, memory write, register write, write-back source, destination register and next-PC source.

The instruction array is filled through a program-load port, and only while reset is held. Two peek ports expose one register and one data word by index. They exist so that the final machine state can be observed from outside.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high the PC, all registers and all data words become 0 on each rising edge. Program-load writes (`prog_we`) take effect only while `rst` is high. The first instruction after reset is fetched from address 0.
- R2: Opcode 0x00 is register-register. It writes register rd [15:11] with rs [25:21] op rt [20:16], where func [5:0] selects the operation: 0x20 add, 0x22 subtract (rs-rt), 0x24 and, 0x25 or, 0x26 xor, 0x2A signed set-less-than (result 1 or 0).
- R3: Immediate ops write rt with rs op imm [15:0]. Sign extension is used by 0x08 add and 0x0A signed set-less-than. Zero extension is used by 0x0C and, 0x0D or and 0x0E xor. Opcode 0x0F writes imm<<16.
- R4: Register 0 always reads as 0, and any write addressed to it is discarded.
- R5: Opcode 0x23 loads the word at rs+sext(imm) into rt. Opcode 0x2B stores rt at rs+sext(imm) and writes no register. Both arrays are word-indexed by address bits [N+1:2].
- R6: Opcode 0x04 branches when rs is 0, and opcode 0x05 branches when rs is nonzero. The branch target is PC+4+(sext(imm)<<2). When the branch is not taken the PC becomes PC+4.
- R7: Opcode 0x02 jumps to {(PC+4)[31:28], target[25:0], 2'b00}. Opcode 0x03 does the same and also writes PC+4 into register 31.
- R8: Opcode 0x16 sets the PC to the value of rs. Opcode 0x17 does the same and also writes PC+4 into register 31, using the value of rs from before that write.
- R9: An undefined opcode, or an undefined func under opcode 0x00, writes nothing and advances the PC by 4.
- R10: Branches and jumps never write the data array. Among them only 0x03 and 0x17 write a register.
- R11: Every instruction that does not redirect control advances the PC by exactly 4 in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Active-high synchronous reset |
| prog_we | input | 1 | Program-load write strobe (honoured only in reset) |
| prog_addr | input | log2(IMEM_WORDS) | Program-load word index |
| prog_data | input | 32 | Program-load instruction word |
| pc_o | output | 32 | Current program counter |
| peek_reg_sel | input | 5 | Register index to observe |
| peek_reg_data | output | 32 | Value of the observed register |
| peek_mem_addr | input | log2(DMEM_WORDS) | Data word index to observe |
| peek_mem_data | output | 32 | Value of the observed data word |

## Verification
The assertions check the following on every cycle: the PC advance for sequential instructions, that register 0 reads as zero on all read ports, that branches and jumps never enable a memory write, that stores never enable a register write, that link instructions write PC+4, and that undefined encodings enable nothing. Other behaviour shows only in the bench's scenarios. This covers the arithmetic results of each operation, the choice of extension mode, the load/store address arithmetic, and the taken and not-taken paths of both branches. It also covers the ordering on 0x17, where the jump target is read before register 31 is overwritten. The bench checks these by tracing the PC every cycle against a reference model and comparing the final registers and data words, for a directed program and for a seeded random one.

// File: rtl/sc_pkg.sv
package sc_pkg;
    localparam int XLEN   = 32;
    localparam int NREGS  = 32;
    localparam int RAW    = $clog2(NREGS);
    localparam int LINK_REG = NREGS - 1;

    localparam logic [5:0] OPC_REG  = 6'h00;
    localparam logic [5:0] OPC_J    = 6'h02;
    localparam logic [5:0] OPC_JL   = 6'h03;
    localparam logic [5:0] OPC_BZ   = 6'h04;
    localparam logic [5:0] OPC_BNZ  = 6'h05;
    localparam logic [5:0] OPC_ADDI = 6'h08;
    localparam logic [5:0] OPC_SLTI = 6'h0A;
    localparam logic [5:0] OPC_ANDI = 6'h0C;
    localparam logic [5:0] OPC_ORI  = 6'h0D;
    localparam logic [5:0] OPC_XORI = 6'h0E;
    localparam logic [5:0] OPC_HIGH = 6'h0F;
    localparam logic [5:0] OPC_JR   = 6'h16;
    localparam logic [5:0] OPC_JRL  = 6'h17;
    localparam logic [5:0] OPC_LDW  = 6'h23;
    localparam logic [5:0] OPC_STW  = 6'h2B;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_XOR = 6'h26;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [1:0] {IMM_SEXT, IMM_ZEXT, IMM_HIGH} imm_mode_e;
    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_SLT, ALU_PASS_A, ALU_PASS_B
    } alu_op_e;
    typedef enum logic [1:0] {WB_ALU, WB_MEM, WB_LINK} wb_sel_e;
    typedef enum logic [1:0] {DST_RT, DST_RD, DST_LINK} dst_e;
    typedef enum logic [2:0] {NPC_SEQ, NPC_BR_Z, NPC_BR_NZ, NPC_REG, NPC_ABS} npc_e;

    typedef struct packed {
        imm_mode_e imm_mode;
        logic      opb_imm;
        alu_op_e   alu_op;
        logic      mem_we;
        logic      rf_we;
        wb_sel_e   wb_sel;
        dst_e      dst_sel;
        npc_e      npc_sel;
    } ctrl_t;
endpackage

// File: rtl/sc_decode.sv
module sc_decode
    import sc_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] func,
    output ctrl_t      ctrl,
    output logic       illegal
);
    always_comb begin
        ctrl.imm_mode = IMM_SEXT;
        ctrl.opb_imm  = 1'b0;
        ctrl.alu_op   = ALU_ADD;
        ctrl.mem_we   = 1'b0;
        ctrl.rf_we    = 1'b0;
        ctrl.wb_sel   = WB_ALU;
        ctrl.dst_sel  = DST_RT;
        ctrl.npc_sel  = NPC_SEQ;
        illegal       = 1'b0;
        unique case (opcode)
            OPC_REG: begin
                ctrl.dst_sel = DST_RD;
                ctrl.rf_we   = 1'b1;
                unique case (func)
                    FN_ADD:  ctrl.alu_op = ALU_ADD;
                    FN_SUB:  ctrl.alu_op = ALU_SUB;
                    FN_AND:  ctrl.alu_op = ALU_AND;
                    FN_OR:   ctrl.alu_op = ALU_OR;
                    FN_XOR:  ctrl.alu_op = ALU_XOR;
                    FN_SLT:  ctrl.alu_op = ALU_SLT;
                    default: begin
                        ctrl.rf_we = 1'b0;
                        illegal    = 1'b1;
                    end
                endcase
            end
            OPC_ADDI, OPC_SLTI: begin
                ctrl.opb_imm = 1'b1;
                ctrl.rf_we   = 1'b1;
                ctrl.alu_op  = (opcode == OPC_ADDI) ? ALU_ADD : ALU_SLT;
            end
            OPC_ANDI, OPC_ORI, OPC_XORI: begin
                ctrl.imm_mode = IMM_ZEXT;
                ctrl.opb_imm  = 1'b1;
                ctrl.rf_we    = 1'b1;
                ctrl.alu_op   = (opcode == OPC_ANDI) ? ALU_AND :
                                (opcode == OPC_ORI)  ? ALU_OR  : ALU_XOR;
            end
            OPC_HIGH: begin
                ctrl.imm_mode = IMM_HIGH;
                ctrl.opb_imm  = 1'b1;
                ctrl.rf_we    = 1'b1;
                ctrl.alu_op   = ALU_PASS_B;
            end
            OPC_LDW: begin
                ctrl.opb_imm = 1'b1;
                ctrl.rf_we   = 1'b1;
                ctrl.wb_sel  = WB_MEM;
            end
            OPC_STW: begin
                ctrl.opb_imm = 1'b1;
                ctrl.mem_we  = 1'b1;
            end
            OPC_BZ, OPC_BNZ: begin
                ctrl.alu_op  = ALU_PASS_A;
                ctrl.npc_sel = (opcode == OPC_BZ) ? NPC_BR_Z : NPC_BR_NZ;
            end
            OPC_J, OPC_JL: begin
                ctrl.npc_sel = NPC_ABS;
                if (opcode == OPC_JL) begin
                    ctrl.rf_we   = 1'b1;
                    ctrl.wb_sel  = WB_LINK;
                    ctrl.dst_sel = DST_LINK;
                end
            end
            OPC_JR, OPC_JRL: begin
                ctrl.npc_sel = NPC_REG;
                if (opcode == OPC_JRL) begin
                    ctrl.rf_we   = 1'b1;
                    ctrl.wb_sel  = WB_LINK;
                    ctrl.dst_sel = DST_LINK;
                end
            end
            default: illegal = 1'b1;
        endcase
    end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y,
    output logic         zero
);
    always_comb begin
        unique case (op)
            ALU_ADD:    y = a + b;
            ALU_SUB:    y = a - b;
            ALU_AND:    y = a & b;
            ALU_OR:     y = a | b;
            ALU_XOR:    y = a ^ b;
            ALU_SLT:    y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            ALU_PASS_A: y = a;
            ALU_PASS_B: y = b;
            default:    y = '0;
        endcase
    end
    assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile
    import sc_pkg::*;
#(
    parameter int W    = XLEN,
    parameter int N    = NREGS,
    parameter int NRD  = 3,
    localparam int AW  = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] rd_sel  [NRD],
    output logic [W-1:0]  rd_data [NRD]
);
    logic [W-1:0] regs [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) regs[i] <= '0;
        end else if (we && (waddr != '0)) begin
            regs[waddr] <= wdata;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rd_data[p] = (rd_sel[p] == '0) ? '0 : regs[rd_sel[p]];

        assert_r0_reads_zero_R4: assert property (
            @(posedge clk) disable iff (rst)
            (rd_sel[p] == '0) |-> (rd_data[p] == '0));
    end
endmodule

// File: rtl/sc_wordmem.sv
module sc_wordmem #(
    parameter int W          = 32,
    parameter int DEPTH      = 64,
    parameter int NRD        = 1,
    parameter bit IS_PROGRAM = 1'b0,
    localparam int AW        = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr [NRD],
    output logic [W-1:0]  rdata [NRD]
);
    logic [W-1:0] mem [DEPTH];

    if (IS_PROGRAM) begin : g_prog
        always_ff @(posedge clk) begin
            if (rst && we) mem[waddr] <= wdata;
        end
    end else begin : g_data
        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (we) begin
                mem[waddr] <= wdata;
            end
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p] = mem[raddr[p]];
    end
endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    localparam int IAW = $clog2(IMEM_WORDS),
    localparam int DAW = $clog2(DMEM_WORDS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            prog_we,
    input  logic [IAW-1:0]  prog_addr,
    input  logic [XLEN-1:0] prog_data,
    output logic [XLEN-1:0] pc_o,
    input  logic [RAW-1:0]  peek_reg_sel,
    output logic [XLEN-1:0] peek_reg_data,
    input  logic [DAW-1:0]  peek_mem_addr,
    output logic [XLEN-1:0] peek_mem_data
);
    logic [XLEN-1:0] pc, pc_plus4, next_pc;
    logic [XLEN-1:0] instr;
    logic [5:0]      f_op, f_fn;
    logic [RAW-1:0]  f_rs, f_rt, f_rd;
    logic [15:0]     f_imm;
    logic [25:0]     f_tgt;
    ctrl_t           ctrl;
    logic            illegal;
    logic [XLEN-1:0] imm_ext, rs_val, rt_val, opb, alu_y, mem_rd, wb_data;
    logic            alu_zero;
    logic [RAW-1:0]  rf_waddr;

    logic [IAW-1:0]  im_raddr [1];
    logic [XLEN-1:0] im_rdata [1];
    logic [DAW-1:0]  dm_raddr [2];
    logic [XLEN-1:0] dm_rdata [2];
    logic [RAW-1:0]  rf_sel   [3];
    logic [XLEN-1:0] rf_data  [3];

    // Fetch
    assign im_raddr[0] = pc[IAW+1:2];
    assign instr       = im_rdata[0];

    sc_wordmem #(.W(XLEN), .DEPTH(IMEM_WORDS), .NRD(1), .IS_PROGRAM(1'b1)) u_imem (
        .clk(clk), .rst(rst), .we(prog_we), .waddr(prog_addr), .wdata(prog_data),
        .raddr(im_raddr), .rdata(im_rdata));

    // Field split
    assign f_op  = instr[31:26];
    assign f_rs  = instr[25:21];
    assign f_rt  = instr[20:16];
    assign f_rd  = instr[15:11];
    assign f_fn  = instr[5:0];
    assign f_imm = instr[15:0];
    assign f_tgt = instr[25:0];

    sc_decode u_dec (.opcode(f_op), .func(f_fn), .ctrl(ctrl), .illegal(illegal));

    // Register read
    assign rf_sel[0] = f_rs;
    assign rf_sel[1] = f_rt;
    assign rf_sel[2] = peek_reg_sel;
    assign rs_val        = rf_data[0];
    assign rt_val        = rf_data[1];
    assign peek_reg_data = rf_data[2];

    always_comb begin
        unique case (ctrl.imm_mode)
            IMM_ZEXT: imm_ext = {16'h0000, f_imm};
            IMM_HIGH: imm_ext = {f_imm, 16'h0000};
            default:  imm_ext = {{16{f_imm[15]}}, f_imm};
        endcase
    end

    assign opb = ctrl.opb_imm ? imm_ext : rt_val;

    sc_alu #(.W(XLEN)) u_alu (.a(rs_val), .b(opb), .op(ctrl.alu_op), .y(alu_y), .zero(alu_zero));

    // Data memory
    assign dm_raddr[0]   = alu_y[DAW+1:2];
    assign dm_raddr[1]   = peek_mem_addr;
    assign mem_rd        = dm_rdata[0];
    assign peek_mem_data = dm_rdata[1];

    sc_wordmem #(.W(XLEN), .DEPTH(DMEM_WORDS), .NRD(2), .IS_PROGRAM(1'b0)) u_dmem (
        .clk(clk), .rst(rst), .we(ctrl.mem_we), .waddr(alu_y[DAW+1:2]), .wdata(rt_val),
        .raddr(dm_raddr), .rdata(dm_rdata));

    // Write-back
    assign pc_plus4 = pc + 32'd4;

    always_comb begin
        unique case (ctrl.wb_sel)
            WB_MEM:  wb_data = mem_rd;
            WB_LINK: wb_data = pc_plus4;
            default: wb_data = alu_y;
        endcase
        unique case (ctrl.dst_sel)
            DST_RD:   rf_waddr = f_rd;
            DST_LINK: rf_waddr = RAW'(LINK_REG);
            default:  rf_waddr = f_rt;
        endcase
    end

    sc_regfile #(.W(XLEN), .N(NREGS), .NRD(3)) u_rf (
        .clk(clk), .rst(rst), .we(ctrl.rf_we), .waddr(rf_waddr), .wdata(wb_data),
        .rd_sel(rf_sel), .rd_data(rf_data));

    // Next PC
    always_comb begin
        unique case (ctrl.npc_sel)
            NPC_BR_Z:  next_pc = alu_zero  ? pc_plus4 + {imm_ext[XLEN-3:0], 2'b00} : pc_plus4;
            NPC_BR_NZ: next_pc = !alu_zero ? pc_plus4 + {imm_ext[XLEN-3:0], 2'b00} : pc_plus4;
            NPC_REG:   next_pc = rs_val;
            NPC_ABS:   next_pc = {pc_plus4[31:28], f_tgt, 2'b00};
            default:   next_pc = pc_plus4;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) pc <= '0;
        else     pc <= next_pc;
    end

    assign pc_o = pc;

    assert_reset_pc_R1: assert property (
        @(posedge clk) disable iff (rst)
        $past(rst) |-> (pc == '0));

    assert_seq_advance_R11: assert property (
        @(posedge clk) disable iff (rst)
        (ctrl.npc_sel == NPC_SEQ) |=> (pc == $past(pc) + 32'd4));

    assert_flow_no_store_R10: assert property (
        @(posedge clk) disable iff (rst)
        (ctrl.npc_sel != NPC_SEQ) |-> (!ctrl.mem_we && (!ctrl.rf_we || rf_waddr == RAW'(LINK_REG))));

    assert_store_no_reg_R5: assert property (
        @(posedge clk) disable iff (rst)
        ctrl.mem_we |-> !ctrl.rf_we);

    assert_link_value_R7: assert property (
        @(posedge clk) disable iff (rst)
        (ctrl.dst_sel == DST_LINK) |-> (ctrl.rf_we && wb_data == pc_plus4));

    assert_undef_nop_R9: assert property (
        @(posedge clk) disable iff (rst)
        illegal |-> (!ctrl.rf_we && !ctrl.mem_we && ctrl.npc_sel == NPC_SEQ));
endmodule

// File: tb/sc_core_tb.sv
`timescale 1ns/1ps
module sc_core_tb;
    localparam int IW = 64;
    localparam int DW = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        prog_we = 1'b0;
    logic [5:0]  prog_addr = '0;
    logic [31:0] prog_data = '0;
    logic [31:0] pc_o;
    logic [4:0]  peek_reg_sel = '0;
    logic [31:0] peek_reg_data;
    logic [5:0]  peek_mem_addr = '0;
    logic [31:0] peek_mem_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] prog [IW];
    logic [31:0] m_rf [32];
    logic [31:0] m_dm [DW];
    logic [31:0] m_pc;

    always #4 clk = ~clk;

    sc_core #(.IMEM_WORDS(IW), .DMEM_WORDS(DW)) u_dut (
        .clk(clk), .rst(rst), .prog_we(prog_we), .prog_addr(prog_addr), .prog_data(prog_data),
        .pc_o(pc_o), .peek_reg_sel(peek_reg_sel), .peek_reg_data(peek_reg_data),
        .peek_mem_addr(peek_mem_addr), .peek_mem_data(peek_mem_data));

    function automatic logic [31:0] enc_r(logic [5:0] fn, logic [4:0] rd, logic [4:0] rs, logic [4:0] rt);
        return {6'h00, rs, rt, rd, 5'd0, fn};
    endfunction
    function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rt, logic [4:0] rs, logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction
    function automatic logic [31:0] enc_j(logic [5:0] op, logic [25:0] tgt);
        return {op, tgt};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic m_wr(logic [4:0] r, logic [31:0] v);
        if (r != 5'd0) m_rf[r] = v;
    endtask

    // Reference model built from the requirements
    task automatic model_step();
        logic [31:0] ins, a, b, sx, zx, pc4, npc, ea;
        logic [5:0]  op, fn;
        logic [4:0]  rs, rt, rd;
        ins = prog[m_pc[7:2]];
        op = ins[31:26]; fn = ins[5:0];
        rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11];
        a  = (rs == 0) ? 32'd0 : m_rf[rs];
        b  = (rt == 0) ? 32'd0 : m_rf[rt];
        sx = {{16{ins[15]}}, ins[15:0]};
        zx = {16'h0, ins[15:0]};
        pc4 = m_pc + 32'd4;
        npc = pc4;
        ea  = a + sx;
        case (op)
            6'h00: case (fn)
                6'h20: m_wr(rd, a + b);
                6'h22: m_wr(rd, a - b);
                6'h24: m_wr(rd, a & b);
                6'h25: m_wr(rd, a | b);
                6'h26: m_wr(rd, a ^ b);
                6'h2A: m_wr(rd, {31'd0, $signed(a) < $signed(b)});
                default: ;
            endcase
            6'h08: m_wr(rt, a + sx);
            6'h0A: m_wr(rt, {31'd0, $signed(a) < $signed(sx)});
            6'h0C: m_wr(rt, a & zx);
            6'h0D: m_wr(rt, a | zx);
            6'h0E: m_wr(rt, a ^ zx);
            6'h0F: m_wr(rt, {ins[15:0], 16'h0});
            6'h23: m_wr(rt, m_dm[ea[7:2]]);
            6'h2B: m_dm[ea[7:2]] = b;
            6'h04: if (a == 0) npc = pc4 + {sx[29:0], 2'b00};
            6'h05: if (a != 0) npc = pc4 + {sx[29:0], 2'b00};
            6'h02: npc = {pc4[31:28], ins[25:0], 2'b00};
            6'h03: begin npc = {pc4[31:28], ins[25:0], 2'b00}; m_wr(5'd31, pc4); end
            6'h16: npc = a;
            6'h17: begin npc = a; m_wr(5'd31, pc4); end
            default: ;
        endcase
        m_pc = npc;
    endtask

    task automatic load_and_reset();
        rst = 1'b1;
        @(negedge clk);
        for (int i = 0; i < IW; i++) begin
            prog_we = 1'b1; prog_addr = 6'(i); prog_data = prog[i];
            @(negedge clk);
        end
        prog_we = 1'b0;
        @(negedge clk);
        // R1: reset state seen at the ports
        check("R1 pc after reset", pc_o, 32'd0);
        peek_reg_sel = 5'd7; #1;
        check("R1 register cleared", peek_reg_data, 32'd0);
        peek_mem_addr = 6'd2; #1;
        check("R1 data word cleared", peek_mem_data, 32'd0);
        for (int i = 0; i < 32; i++) m_rf[i] = '0;
        for (int i = 0; i < DW; i++) m_dm[i] = '0;
        m_pc = '0;
        rst = 1'b0;
    endtask

    task automatic run(int cycles);
        for (int c = 0; c < cycles; c++) begin
            check("R11 pc trace", pc_o, m_pc);
            model_step();
            @(negedge clk);
        end
    endtask

    task automatic peek_reg(logic [4:0] r, output logic [31:0] v);
        peek_reg_sel = r; #1; v = peek_reg_data;
    endtask
    task automatic peek_mem(logic [5:0] w, output logic [31:0] v);
        peek_mem_addr = w; #1; v = peek_mem_data;
    endtask

    task automatic compare_all(string tag, int nwords);
        logic [31:0] v;
        for (int r = 0; r < 32; r++) begin
            peek_reg(5'(r), v);
            check(tag, v, m_rf[r]);
        end
        for (int w = 0; w < nwords; w++) begin
            peek_mem(6'(w), v);
            check(tag, v, m_dm[w]);
        end
    endtask

    task automatic cr(string tag, logic [4:0] r, logic [31:0] exp);
        logic [31:0] v;
        peek_reg(r, v);
        check(tag, v, exp);
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd2024));
        for (int i = 0; i < IW; i++) prog[i] = '0;
        prog[0]  = enc_i(6'h0D, 1, 0, 16'h00FF);
        prog[1]  = enc_i(6'h08, 2, 0, 16'hFFFD);
        prog[2]  = enc_i(6'h0F, 3, 0, 16'h1234);
        prog[3]  = enc_i(6'h0D, 3, 3, 16'h8000);
        prog[4]  = enc_r(6'h20, 4, 1, 2);
        prog[5]  = enc_r(6'h22, 5, 2, 1);
        prog[6]  = enc_r(6'h24, 6, 3, 2);
        prog[7]  = enc_r(6'h25, 7, 1, 3);
        prog[8]  = enc_r(6'h26, 8, 3, 2);
        prog[9]  = enc_r(6'h2A, 9, 2, 1);
        prog[10] = enc_i(6'h0A, 10, 1, 16'hFFFF);
        prog[11] = enc_i(6'h0E, 11, 1, 16'hFFFF);
        prog[12] = enc_i(6'h0C, 12, 2, 16'h8001);
        prog[13] = enc_i(6'h08, 0, 0, 16'd5);
        prog[14] = enc_i(6'h2B, 7, 0, 16'd8);
        prog[15] = enc_i(6'h08, 13, 0, 16'h0040);
        prog[16] = enc_i(6'h2B, 4, 13, 16'hFFFC);
        prog[17] = enc_i(6'h23, 14, 0, 16'd8);
        prog[18] = enc_i(6'h23, 0, 0, 16'd8);
        prog[19] = enc_i(6'h04, 0, 0, 16'd1);
        prog[20] = enc_i(6'h08, 15, 0, 16'd1);
        prog[21] = enc_i(6'h05, 0, 0, 16'd1);
        prog[22] = enc_i(6'h08, 16, 0, 16'd7);
        prog[23] = enc_i(6'h05, 0, 16, 16'd1);
        prog[24] = enc_i(6'h08, 17, 0, 16'd1);
        prog[25] = enc_j(6'h03, 26'd28);
        prog[26] = enc_i(6'h08, 18, 0, 16'd1);
        prog[27] = enc_i(6'h08, 18, 0, 16'd2);
        prog[28] = enc_r(6'h20, 24, 31, 0);
        prog[29] = enc_i(6'h08, 19, 0, 16'h0080);
        prog[30] = enc_i(6'h17, 0, 19, 16'd0);
        prog[31] = enc_i(6'h08, 20, 0, 16'd1);
        prog[32] = enc_i(6'h08, 21, 0, 16'h008C);
        prog[33] = enc_i(6'h16, 0, 21, 16'd0);
        prog[34] = enc_i(6'h08, 22, 0, 16'd1);
        prog[35] = 32'hFFFF_FFFF;
        prog[36] = enc_r(6'h3F, 23, 1, 1);
        prog[37] = enc_j(6'h02, 26'd37);

        load_and_reset();
        run(50);

        cr("R3 zero-extended or", 1, 32'h0000_00FF);
        cr("R3 sign-extended add", 2, 32'hFFFF_FFFD);
        cr("R3 high placement then zext or", 3, 32'h1234_8000);
        cr("R2 add", 4, 32'h0000_00FC);
        cr("R2 subtract", 5, 32'hFFFF_FEFE);
        cr("R2 and", 6, 32'h1234_8000);
        cr("R2 or", 7, 32'h1234_80FF);
        cr("R2 xor", 8, 32'hEDCB_7FFD);
        cr("R2 signed slt", 9, 32'd1);
        cr("R3 signed slti", 10, 32'd0);
        cr("R3 zext xori", 11, 32'h0000_FF00);
        cr("R3 zext andi", 12, 32'h0000_8001);
        cr("R4 register 0 after writes", 0, 32'd0);
        cr("R5 load", 14, 32'h1234_80FF);
        peek_mem(6'd2, v);  check("R5 store positive disp", v, 32'h1234_80FF);
        peek_mem(6'd15, v); check("R5 store negative disp", v, 32'h0000_00FC);
        cr("R6 branch-if-zero taken skips", 15, 32'd0);
        cr("R6 branch-if-nonzero not taken", 16, 32'd7);
        cr("R6 branch-if-nonzero taken skips", 17, 32'd0);
        cr("R7 jump-and-link skips", 18, 32'd0);
        cr("R7 link value", 24, 32'h0000_0068);
        cr("R8 register-jump-and-link link", 31, 32'h0000_007C);
        cr("R8 register-jump-and-link skips", 20, 32'd0);
        cr("R8 register-jump skips", 22, 32'd0);
        cr("R9 undefined func no write", 23, 32'd0);
        check("R7 self jump holds pc", pc_o, 32'h0000_0094);
        peek_mem(6'd0, v);  check("R10 no stray data write", v, 32'd0);
        compare_all("R2 R3 R5 R10 directed model", 16);

        // Seeded random ALU/memory program
        for (int i = 0; i < IW; i++) prog[i] = '0;
        for (int i = 0; i < 48; i++) begin
            int k;
            logic [4:0] ra, rb, rc;
            k  = int'($urandom % 10);
            ra = 5'($urandom % 8); rb = 5'($urandom % 8); rc = 5'($urandom % 8);
            case (k)
                0, 1, 2, 3, 4: begin
                    logic [5:0] fns [6];
                    fns = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h26, 6'h2A};
                    prog[i] = enc_r(fns[$urandom % 6], ra, rb, rc);
                end
                5, 6, 7: begin
                    logic [5:0] ops [6];
                    ops = '{6'h08, 6'h0A, 6'h0C, 6'h0D, 6'h0E, 6'h0F};
                    prog[i] = enc_i(ops[$urandom % 6], ra, rb, 16'($urandom));
                end
                8: prog[i] = enc_i(6'h2B, ra, 0, 16'(($urandom % 16) * 4));
                default: prog[i] = enc_i(6'h23, ra, 0, 16'(($urandom % 16) * 4));
            endcase
        end
        prog[48] = enc_j(6'h02, 26'd48);

        load_and_reset();
        run(60);
        compare_all("R2 R3 R4 R5 random model", 16);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule